// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between on-chip logic and an external asynchronous static RAM of 128K bytes (17-bit word address, 8-bit bidirectional data). Internal logic presents one transfer at a time with a request strobe, a read/write select, an address and write data. The block answers each accepted transfer with a one-clock done pulse, and a read also returns its data. Toward the memory it produces an active-low select, an active-high second select, an active-low write strobe and an active-low output enable. It also drives the address and controls the output driver of the data pads, using a data output, a driver enable and a data input.

Every phase is a whole number of system clocks. Two parameters set the count: the clock period and the speed grade (55 or 70). The count is the nanosecond minimum divided by the period and rounded up. The memory is selected only while a transfer runs and otherwise sits in standby. A write holds output enable high for its whole length. The pad driver is on only during the low part of the write strobe and one cycle after it. A write that follows a read waits until the memory has had its float time to release the bus.

The state machine has six states.
- IDLE: nothing selected, ready high.
- RD_ACCESS: read in progress.
- TURN: dead time before a write.
- WR_SETUP: select asserted, write strobe high.
- WR_PULSE: write strobe low.
- WR_HOLD: write strobe high again, select still held.

The transitions are:
- IDLE→RD_ACCESS: read accepted.
- IDLE→WR_SETUP: write accepted and the float window is over.
- IDLE→TURN: write accepted while the float window is still running.
- TURN→WR_SETUP: float window over.
- WR_SETUP→WR_PULSE: after one cycle.
- WR_PULSE→WR_HOLD: pulse count expired.
- WR_HOLD→IDLE: done.
- RD_ACCESS→IDLE: access count expired; data is captured and done is raised.

Top module: `sram_xfer_ctrl`

## Requirements
- R1: After reset, and in every cycle when `req_ready` is high, the memory is deselected (`mem_ce_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. Right after reset `rsp_valid`=0 and `rsp_rdata`=0.
- R2: A read holds `mem_ce_n`=0, `mem_ce2`=1, `mem_we_n`=1 and `mem_oe_n`=0 with `mem_addr` steady for exactly RD_CYC cycles. RD_CYC is the ceiling of the grade time over the clock period, which is 14 at the default values. `rsp_valid` rises RD_CYC cycles after the accepting edge.
- R3: Read data is sampled from `mem_dq_in` at the clock edge that ends the last access cycle. It appears on `rsp_rdata` together with `rsp_valid` and is held there until the next read completes.
- R4: A write consists of one setup cycle (selected, `mem_we_n`=1), then exactly WP_CYC cycles with `mem_we_n`=0 (14 at default), then one hold cycle (selected, `mem_we_n`=1). With no recent read, `rsp_valid` comes WP_CYC+2 cycles after the accepting edge.
- R5: `mem_dq_oe` is 1 only during the low write strobe and the hold cycle after it. `mem_dq_out` carries the accepted write data during that time, so the memory stores that data at the terminating edge.
- R6: `mem_oe_n` stays 1 for the whole of every write, and `mem_oe_n`=0 never coincides with `mem_dq_oe`=1.
- R7: After a read ends, the write setup cycle starts no earlier than FLT_CYC+1 edges later. FLT_CYC is the ceiling of the float time over the period: 25 ns, or 30 ns for grade 70, which gives 7 at default. Until then both selects stay deasserted. A write accepted inside this window waits in TURN; one accepted after it starts at once.
- R8: A request is taken only on an edge where `req_valid` and `req_ready` are both high. A request raised and withdrawn while busy has no effect. Every accepted transfer produces exactly one `rsp_valid` pulse of one cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address of the transfer |
| req_wdata | input | 8 | Data for a write |
| req_ready | output | 1 | High when a request can be taken |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 8 | Data of the last completed read |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Active-low memory select |
| mem_ce2 | output | 1 | Active-high second memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data toward the pads |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 8 | Data from the pads |

## Verification
The hardest situation to reach is a write whose acceptance falls partway through the float window after a read. In that case the TURN state waits for only part of its length, and the write latency depends on the exact idle gap. The stimulus issues writes immediately after read completions and after gaps of zero to three idle cycles. The bench predicts each latency from the cycle at which the preceding read ended. Its memory model returns wrong data until the address has been steady with output enable low for the full access count, so any early capture appears as a data miscompare. A request that is raised and then dropped while a write is running is checked by reading back its target address.

// File: rtl/sram_xfer_pkg.sv
`timescale 1ns/1ps
package sram_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } xfer_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // cycle/pulse/access minimum of the selected grade, in ns
    function automatic int grade_access_ns(input int grade);
        return (grade == 70) ? 70 : 55;
    endfunction

    // output float time after deselect or output disable, in ns
    function automatic int grade_float_ns(input int grade);
        return (grade == 70) ? 30 : 25;
    endfunction

    function automatic bool_sel(input xfer_state_e st);
        return (st == ST_RD_ACCESS) || (st == ST_WR_SETUP) ||
               (st == ST_WR_PULSE)  || (st == ST_WR_HOLD);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (capture) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/sram_xfer_ctrl.sv
`timescale 1ns/1ps
module sram_xfer_ctrl
    import sram_xfer_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int SPEED_GRADE   = 55,
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Phase lengths in whole clocks, rounded up from the grade minimums
    localparam int RD_CYC  = ceil_div(grade_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int WP_CYC  = ceil_div(grade_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int FLT_CYC = ceil_div(grade_float_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int TMAX    = (RD_CYC > FLT_CYC) ? ((RD_CYC > WP_CYC) ? RD_CYC : WP_CYC)
                                                : ((FLT_CYC > WP_CYC) ? FLT_CYC : WP_CYC);
    localparam int CNT_W   = $clog2(TMAX + 1);

    xfer_state_e state_q, state_d;

    logic             accept;
    logic             ph_load;
    logic [CNT_W-1:0] ph_val;
    logic             ph_done;
    logic             rec_load;
    logic             rec_done;
    logic             cap;
    logic             done_d;

    // Phase length timer for read access and write strobe
    sram_phase_timer #(.W(CNT_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_done)
    );

    // Bus float window started when a read releases the memory
    sram_phase_timer #(.W(CNT_W)) u_float_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rec_load),
        .load_val (CNT_W'(FLT_CYC)),
        .expired  (rec_done)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_rd_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .din     (mem_dq_in),
        .dout    (rsp_rdata)
    );

    assign req_ready = (state_q == ST_IDLE);

    // Next state and phase control
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        ph_load  = 1'b0;
        ph_val   = '0;
        rec_load = 1'b0;
        cap      = 1'b0;
        done_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (!req_write) begin
                        state_d = ST_RD_ACCESS;
                        ph_load = 1'b1;
                        ph_val  = CNT_W'(RD_CYC - 1);
                    end else if (rec_done) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_TURN;
                    end
                end
            end
            ST_TURN: begin
                if (rec_done) begin
                    state_d = ST_WR_SETUP;
                end
            end
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                ph_load = 1'b1;
                ph_val  = CNT_W'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (ph_done) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            ST_RD_ACCESS: begin
                if (ph_done) begin
                    state_d  = ST_IDLE;
                    cap      = 1'b1;
                    done_d   = 1'b1;
                    rec_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n   <= 1'b1;
            mem_ce2    <= 1'b0;
            mem_we_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rsp_valid  <= 1'b0;
        end else begin
            mem_ce_n  <= !bool_sel(state_d);
            mem_ce2   <= bool_sel(state_d);
            mem_we_n  <= (state_d != ST_WR_PULSE);
            mem_oe_n  <= (state_d != ST_RD_ACCESS);
            mem_dq_oe <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
            rsp_valid <= done_d;
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/sram_xfer_ctrl_chk.sv
`timescale 1ns/1ps
module sram_xfer_ctrl_chk
    import sram_xfer_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int SPEED_GRADE   = 55,
    parameter int ADDR_W        = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    localparam int WP_CYC  = ceil_div(grade_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int FLT_CYC = ceil_div(grade_float_ns(SPEED_GRADE), CLK_PERIOD_NS);

    logic [7:0] we_run;
    logic [7:0] since_oe;
    logic       selected;

    assign selected = !mem_ce_n && mem_ce2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run   <= '0;
            since_oe <= 8'hFF;
        end else begin
            we_run   <= mem_we_n ? 8'd0 : we_run + 8'd1;
            since_oe <= !mem_oe_n ? 8'd0 : ((since_oe == 8'hFF) ? since_oe : since_oe + 8'd1);
        end
    end

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R2
    read_addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    // R4
    strobe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> selected);

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_run) == WP_CYC && selected));

    // R5
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (selected && (!mem_we_n || $past(!mem_we_n))));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R7
    float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (int'(since_oe) >= FLT_CYC));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind sram_xfer_ctrl sram_xfer_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .SPEED_GRADE   (SPEED_GRADE),
    .ADDR_W        (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/sram_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module sram_xfer_ctrl_tb;

    localparam int EXP_RD  = (55 + 3) / 4;   // 14
    localparam int EXP_WP  = (55 + 3) / 4;   // 14
    localparam int EXP_FLT = (25 + 3) / 4;   // 7

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    always #2 clk = ~clk;

    sram_xfer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    typedef struct {
        bit       is_wr;
        bit [7:0] data;
        int       acc_cyc;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] model_mem [int];
    logic [7:0] ref_mem [int];
    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  done_flag = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Memory model: data valid only after a full access with stable address
    int          acc_run = 0;
    logic [16:0] prev_addr = '0;
    always @(negedge clk) begin
        logic [7:0] v;
        if (!mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n)
            acc_run = (mem_addr == prev_addr && acc_run > 0) ? acc_run + 1 : 1;
        else
            acc_run = 0;
        prev_addr = mem_addr;
        v = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
        mem_dq_in = (acc_run >= EXP_RD) ? v : ~v;
    end

    // Monitor / scoreboard
    int          we_run = 0, oe_run = 0, since_oe = 1000;
    int          last_rd_end = -1000;
    logic [7:0]  last_rd = 8'h00;
    logic [16:0] pend_addr;
    logic [7:0]  pend_data;
    bit          prev_rsp = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit sel;
            sel = !mem_ce_n && mem_ce2;
            if (req_ready)
                chk(!sel && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle standby",
                    {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
            if (mem_dq_oe)
                chk(mem_oe_n, "R6 oe_n high while driving", mem_oe_n, 1);
            if (!mem_we_n) begin
                if (we_run == 0)
                    chk(since_oe >= EXP_FLT, "R7 float gap before write", since_oe, EXP_FLT);
                chk(sel && mem_dq_oe && mem_oe_n, "R5 strobe low drive", {sel, mem_dq_oe, mem_oe_n}, 3'b111);
                pend_addr = mem_addr;
                pend_data = mem_dq_out;
                we_run++;
            end else if (we_run > 0) begin
                chk(we_run == EXP_WP, "R4 strobe width", we_run, EXP_WP);
                chk(sel && mem_dq_oe, "R5 hold cycle", {sel, mem_dq_oe}, 2'b11);
                model_mem[int'(pend_addr)] = pend_data;
                we_run = 0;
            end else begin
                chk(!mem_dq_oe, "R5 driver off", mem_dq_oe, 0);
            end
            if (!mem_oe_n) begin
                chk(sel && mem_we_n, "R2 read pins", {sel, mem_we_n}, 2'b11);
                oe_run++;
            end else if (oe_run > 0) begin
                chk(oe_run == EXP_RD, "R2 read length", oe_run, EXP_RD);
                oe_run = 0;
            end
            since_oe = !mem_oe_n ? 0 : since_oe + 1;
            if (rsp_valid) begin
                chk(!prev_rsp, "R8 single pulse", prev_rsp, 0);
                if (sb_q.size() == 0) begin
                    chk(0, "R8 unexpected response", 1, 0);
                end else begin
                    item_t it;
                    int lat;
                    it = sb_q.pop_front();
                    lat = cyc - it.acc_cyc;
                    if (!it.is_wr) begin
                        chk(rsp_rdata == it.data, "R3 read data", rsp_rdata, it.data);
                        chk(lat == EXP_RD, "R2 read latency", lat, EXP_RD);
                        last_rd_end = cyc;
                        last_rd = it.data;
                    end else begin
                        int setup, exp_lat;
                        setup = (it.acc_cyc > last_rd_end + EXP_FLT + 1) ? it.acc_cyc
                                                                          : last_rd_end + EXP_FLT + 1;
                        exp_lat = setup - it.acc_cyc + EXP_WP + 2;
                        if (setup > it.acc_cyc)
                            chk(lat == exp_lat, "R7 write latency with turnaround", lat, exp_lat);
                        else
                            chk(lat == exp_lat, "R4 write latency", lat, exp_lat);
                        chk(rsp_rdata == last_rd, "R3 read data held", rsp_rdata, last_rd);
                    end
                end
            end
            prev_rsp = rsp_valid;
        end
    end

    // Driver
    task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        it.is_wr   = wr;
        it.acc_cyc = cyc;
        if (wr) begin
            ref_mem[int'(a)] = d;
            it.data = d;
        end else begin
            it.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
        end
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
            "R1 reset pins", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 6'b101101);
        chk(!rsp_valid && rsp_rdata == 8'h00, "R1 reset response", {rsp_valid, rsp_rdata}, 0);

        // Boundary addresses, then read back (R2, R3, R4)
        do_op(1, 17'h00000, 8'h3C);
        do_op(1, 17'h1FFFF, 8'hC3);
        do_op(0, 17'h00000, 8'h00);
        do_op(0, 17'h1FFFF, 8'h00);
        // Write straight after a read: full turnaround (R7)
        do_op(1, 17'h0A5A5, 8'h5A);
        do_op(0, 17'h0A5A5, 8'h00);
        // Long gap after a read: no turnaround (R4, R7)
        repeat (20) @(negedge clk);
        do_op(1, 17'h01234, 8'h81);

        // Request raised and withdrawn while busy is ignored (R8)
        do_op(1, 17'h00777, 8'h11);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 17'h0A5A5;
        req_wdata = 8'h77;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        do_op(0, 17'h0A5A5, 8'h00);
        do_op(0, 17'h00777, 8'h00);

        // Mixed traffic with varying idle gaps inside the float window (R7)
        for (int i = 0; i < 30; i++) begin
            logic [16:0] a;
            a = 17'((i % 6) * 21845 + 3);
            repeat (i % 4) @(negedge clk);
            do_op((i % 3) != 1, a, 8'((i * 29 + 7) & 8'hFF));
        end
        // Back-to-back reads (R2, R3)
        for (int i = 0; i < 6; i++) do_op(0, 17'(i * 21845 + 3), 8'h00);

        repeat (40) @(negedge clk);
        chk(sb_q.size() == 0, "R8 all responses seen", sb_q.size(), 0);
        finish_run();
    end

endmodule